// File: doc/BRIEF.md
# Authenticated-Cipher Input Front End

This block sits ahead of an authenticated-encryption cipher core. It takes two independent streams, each with its own valid/ready handshake. The public stream carries instruction words, segment headers and segment data. The secret stream carries key material. The block stages incoming key words and hands a staged key to the core on an activate-key instruction. It then chooses encryption or decryption from the next instruction, and reads the segment headers that follow.

Data words are shifted into a register as wide as one cipher block. A block goes to the core when it is full or when its segment ends. A short final block is padded with one 0x80 byte followed by zeros, and it carries a byte count and a one-hot marker for the pad byte. Each block also carries flags: segment type, associated data, last block of its segment, last block of the input, empty message, and decryption. On decryption the tag segment is not sent as blocks. It is gathered into a tag register for the core to compare. Every instruction and header word is also copied to a bypass output for the output side.

Top module: `aead_inflow`

## Requirements
- R1: After reset, `pub_ready` and `sec_ready` are high, and `cb_valid`, `xtag_ready` and `key_fresh` are low.
- R2: Secret words are shifted into a staging register, with the first word ending up most significant. Once KEY/SW words have arrived, `sec_ready` stays low and `key_out` keeps its old value until an activate instruction consumes the staged key.
- R3: An instruction word whose top nibble is 0x7 activates a key. `pub_ready` stays low until a staged key exists. The next cycle copies the staged key to `key_out`, raises `key_fresh` for exactly one cycle, and reopens both input ports.
- R4: Instruction nibble 0x2 selects encryption and 0x3 selects decryption, and `cb_decrypt` reports which one is active. Any other instruction nibble, apart from 0x7, is accepted and ignored: no block is produced and the next word is still read as an instruction.
- R5: A header word holds the segment type in its top nibble and the byte length in its low 16 bits. The type codes are 1 = public nonce, 2 = secret nonce, 3 = associated data, 4 = message, 5 = tag. Every accepted instruction or header word appears on `hdr_data`, with `hdr_valid` high for one cycle.
- R6: Data words fill the block starting at the most significant W bits. A block is presented when BLK/W words have been collected or when the segment's byte count runs out. Every block that does not end its segment has `cb_bytes` = BLK/8.
- R7: While `cb_valid` is high, `pub_ready` is low. `cb_valid`, `cb_data` and `cb_bytes` hold until `cb_take` is sampled high, after which `cb_valid` falls.
- R8: Byte i of `cb_data` is counted from the most significant end. Bytes below `cb_bytes` carry input data. If `cb_bytes` < BLK/8, byte `cb_bytes` is 0x80, `cb_padpos` has only bit `cb_bytes` set, and all later bytes are zero, whatever the input word held there. A full block has `cb_padpos` = 0.
- R9: `cb_last_seg` is high on the final block of every segment. `cb_last_all` is high only on the final block of the message segment. `cb_type` equals the segment's type code, and `cb_is_ad` is high exactly for type 3.
- R10: A zero-length segment of type 1, 2 or 3 produces no block. A zero-length message segment produces one block with `cb_bytes` = 0, `cb_empty`, `cb_last_seg` and `cb_last_all` high, and byte 0 = 0x80.
- R11: The tag segment on decryption is shifted into `xtag`, with the first word most significant. `xtag_ready` rises once the segment's last byte has arrived, and falls when the next instruction word is accepted.
- R12: After the message segment the next word is read as an instruction when encrypting. When decrypting, the next word is read as a header, and only after the tag does the block return to reading instructions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pub_data | input | W | Public stream word |
| pub_valid | input | 1 | Public word offered |
| pub_ready | output | 1 | Public word can be taken |
| sec_data | input | SW | Secret key word |
| sec_valid | input | 1 | Secret word offered |
| sec_ready | output | 1 | Secret word can be taken |
| key_out | output | KEY | Active key |
| key_fresh | output | 1 | One-cycle pulse when the active key changes |
| cb_data | output | BLK | Padded block for the cipher core |
| cb_bytes | output | clog2(BLK/8+1) | Valid bytes in the block |
| cb_padpos | output | BLK/8 | One-hot position of the pad byte |
| cb_valid | output | 1 | Block waiting |
| cb_take | input | 1 | Core reads the waiting block |
| cb_last_seg | output | 1 | Final block of the segment |
| cb_last_all | output | 1 | Final block of all data |
| cb_empty | output | 1 | Empty message marker |
| cb_is_ad | output | 1 | Block is associated data |
| cb_type | output | 4 | Segment type code |
| cb_decrypt | output | 1 | Decryption in progress |
| xtag | output | TAG | Expected tag gathered on decryption |
| xtag_ready | output | 1 | Expected tag complete |
| hdr_data | output | W | Copied instruction or header word |
| hdr_valid | output | 1 | Copy valid for one cycle |

## Verification
A wrong remaining-byte count shows up at once as a block presented one word early or late. The fault then carries over into the following header, which gets read as data, so a bad count never stays hidden past the end of its segment. A wrong fill counter or size accumulator changes `cb_bytes` and the pad position in the same cycle the block appears. A state register left in the wrong mode is exposed by the word after the message or tag: a header-shaped word that is taken as data, or an instruction that is taken as a header, produces a block where none is due.

// File: rtl/aead_inflow.sv
module aead_inflow #(
  parameter int W   = 32,
  parameter int SW  = 32,
  parameter int BLK = 128,
  parameter int KEY = 128,
  parameter int TAG = 128
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [W-1:0]                  pub_data,
  input  logic                          pub_valid,
  output logic                          pub_ready,
  input  logic [SW-1:0]                 sec_data,
  input  logic                          sec_valid,
  output logic                          sec_ready,
  output logic [KEY-1:0]                key_out,
  output logic                          key_fresh,
  output logic [BLK-1:0]                cb_data,
  output logic [$clog2(BLK/8+1)-1:0]    cb_bytes,
  output logic [BLK/8-1:0]              cb_padpos,
  output logic                          cb_valid,
  input  logic                          cb_take,
  output logic                          cb_last_seg,
  output logic                          cb_last_all,
  output logic                          cb_empty,
  output logic                          cb_is_ad,
  output logic [3:0]                    cb_type,
  output logic                          cb_decrypt,
  output logic [TAG-1:0]                xtag,
  output logic                          xtag_ready,
  output logic [W-1:0]                  hdr_data,
  output logic                          hdr_valid
);
  localparam int WB  = W / 8;
  localparam int BB  = BLK / 8;
  localparam int WPB = BLK / W;
  localparam int KW  = KEY / SW;
  localparam int SZW = $clog2(BB + 1);
  localparam int WCW = (WPB > 1) ? $clog2(WPB) : 1;
  localparam int KCW = (KW > 1) ? $clog2(KW) : 1;

  localparam logic [3:0] OP_ACT = 4'h7;
  localparam logic [3:0] OP_ENC = 4'h2;
  localparam logic [3:0] OP_DEC = 4'h3;
  localparam logic [3:0] T_AD   = 4'h3;
  localparam logic [3:0] T_MSG  = 4'h4;
  localparam logic [3:0] T_TAG  = 4'h5;

  typedef enum logic [2:0] {S_OP, S_KEY, S_HDR, S_DAT, S_TAG} st_t;

  st_t              st;
  logic             dec_q;
  logic [3:0]       styp;
  logic [15:0]      rem;
  logic [BLK-1:0]   sipo;
  logic [WCW-1:0]   wcnt;
  logic [SZW-1:0]   sz;
  logic [KEY-1:0]   kst;
  logic [KCW-1:0]   kcnt;
  logic             kfull;

  wire              take   = pub_valid & pub_ready;
  wire [3:0]        op     = pub_data[W-1 -: 4];
  wire [15:0]       hlen   = pub_data[15:0];
  wire              lastw  = rem <= 16'(WB);
  wire [SZW-1:0]    nb     = lastw ? SZW'(rem) : SZW'(WB);
  wire              blkful = wcnt == WCW'(WPB - 1);

  assign pub_ready   = (st != S_KEY) & ~cb_valid;
  assign sec_ready   = ~kfull;
  assign cb_bytes    = sz;
  assign cb_type     = styp;
  assign cb_is_ad    = styp == T_AD;
  assign cb_last_all = cb_last_seg & (styp == T_MSG);
  assign cb_decrypt  = dec_q;

  for (genvar i = 0; i < BB; i++) begin : g_pad
    assign cb_data[BLK-1-8*i -: 8] = (SZW'(i) < sz) ? sipo[BLK-1-8*i -: 8] :
                                     (SZW'(i) == sz) ? 8'h80 : 8'h00;
    assign cb_padpos[i] = SZW'(i) == sz;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= S_OP;
      dec_q       <= 1'b0;
      styp        <= 4'h0;
      rem         <= '0;
      sipo        <= '0;
      wcnt        <= '0;
      sz          <= '0;
      kst         <= '0;
      kcnt        <= '0;
      kfull       <= 1'b0;
      key_out     <= '0;
      key_fresh   <= 1'b0;
      cb_valid    <= 1'b0;
      cb_last_seg <= 1'b0;
      cb_empty    <= 1'b0;
      xtag        <= '0;
      xtag_ready  <= 1'b0;
      hdr_data    <= '0;
      hdr_valid   <= 1'b0;
    end else begin
      hdr_valid <= 1'b0;
      key_fresh <= 1'b0;
      if (cb_valid && cb_take) begin
        cb_valid <= 1'b0;
        sz       <= '0;
        wcnt     <= '0;
      end
      if (sec_valid && sec_ready) begin
        kst <= KEY'({kst, sec_data});
        if (kcnt == KCW'(KW - 1)) begin
          kcnt  <= '0;
          kfull <= 1'b1;
        end else begin
          kcnt <= kcnt + 1'b1;
        end
      end
      case (st)
        S_OP: if (take) begin
          hdr_valid  <= 1'b1;
          hdr_data   <= pub_data;
          xtag_ready <= 1'b0;
          case (op)
            OP_ACT: st <= S_KEY;
            OP_ENC: begin dec_q <= 1'b0; st <= S_HDR; end
            OP_DEC: begin dec_q <= 1'b1; st <= S_HDR; end
            default: ;
          endcase
        end
        S_KEY: if (kfull) begin
          key_out   <= kst;
          kfull     <= 1'b0;
          key_fresh <= 1'b1;
          st        <= S_OP;
        end
        S_HDR: if (take) begin
          hdr_valid <= 1'b1;
          hdr_data  <= pub_data;
          styp      <= op;
          rem       <= hlen;
          if (op == T_TAG) begin
            if (hlen == 16'd0) begin
              xtag_ready <= 1'b1;
              st         <= S_OP;
            end else begin
              st <= S_TAG;
            end
          end else if (hlen == 16'd0) begin
            if (op == T_MSG) begin
              cb_valid    <= 1'b1;
              sz          <= '0;
              cb_last_seg <= 1'b1;
              cb_empty    <= 1'b1;
              st          <= dec_q ? S_HDR : S_OP;
            end
          end else begin
            st <= S_DAT;
          end
        end
        S_DAT: if (take) begin
          for (int i = 0; i < WPB; i++)
            if (wcnt == WCW'(i)) sipo[BLK-1-i*W -: W] <= pub_data;
          rem <= rem - 16'(nb);
          sz  <= sz + nb;
          if (lastw) begin
            cb_valid    <= 1'b1;
            cb_last_seg <= 1'b1;
            cb_empty    <= 1'b0;
            st          <= (styp == T_MSG && !dec_q) ? S_OP : S_HDR;
          end else if (blkful) begin
            cb_valid    <= 1'b1;
            cb_last_seg <= 1'b0;
            cb_empty    <= 1'b0;
          end else begin
            wcnt <= wcnt + 1'b1;
          end
        end
        S_TAG: if (take) begin
          xtag <= TAG'({xtag, pub_data});
          rem  <= rem - 16'(nb);
          if (lastw) begin
            xtag_ready <= 1'b1;
            st         <= S_OP;
          end
        end
        default: st <= S_OP;
      endcase
    end
  end

  // R7
  blk_hold_chk: assert property (@(posedge clk) disable iff (rst)
    cb_valid && !cb_take |=> cb_valid && $stable(cb_data) && $stable(cb_bytes));

  // R6
  mid_full_chk: assert property (@(posedge clk) disable iff (rst)
    cb_valid && !cb_last_seg |-> cb_bytes == SZW'(BB));

  // R10
  empty_msg_chk: assert property (@(posedge clk) disable iff (rst)
    cb_valid && cb_empty |-> cb_bytes == '0 && cb_last_all);

  // R3
  key_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    key_fresh |=> !key_fresh);

  // R2
  key_free_chk: assert property (@(posedge clk) disable iff (rst)
    key_fresh |-> sec_ready);

  // R11
  tag_hold_chk: assert property (@(posedge clk) disable iff (rst)
    xtag_ready && !pub_valid |=> xtag_ready && $stable(xtag));

endmodule

// File: tb/aead_inflow_test.sv
`timescale 1ns/1ps
module aead_inflow_test;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [31:0]  pub_data = '0;
  logic         pub_valid = 1'b0;
  logic         pub_ready;
  logic [31:0]  sec_data = '0;
  logic         sec_valid = 1'b0;
  logic         sec_ready;
  logic [127:0] key_out;
  logic         key_fresh;
  logic [127:0] cb_data;
  logic [4:0]   cb_bytes;
  logic [15:0]  cb_padpos;
  logic         cb_valid;
  logic         cb_take = 1'b0;
  logic         cb_last_seg, cb_last_all, cb_empty, cb_is_ad, cb_decrypt;
  logic [3:0]   cb_type;
  logic [127:0] xtag;
  logic         xtag_ready;
  logic [31:0]  hdr_data;
  logic         hdr_valid;

  int errors = 0;
  int checks = 0;

  always #4 clk = ~clk;

  aead_inflow uut (
    .clk(clk), .rst(rst),
    .pub_data(pub_data), .pub_valid(pub_valid), .pub_ready(pub_ready),
    .sec_data(sec_data), .sec_valid(sec_valid), .sec_ready(sec_ready),
    .key_out(key_out), .key_fresh(key_fresh),
    .cb_data(cb_data), .cb_bytes(cb_bytes), .cb_padpos(cb_padpos),
    .cb_valid(cb_valid), .cb_take(cb_take),
    .cb_last_seg(cb_last_seg), .cb_last_all(cb_last_all), .cb_empty(cb_empty),
    .cb_is_ad(cb_is_ad), .cb_type(cb_type), .cb_decrypt(cb_decrypt),
    .xtag(xtag), .xtag_ready(xtag_ready),
    .hdr_data(hdr_data), .hdr_valid(hdr_valid)
  );

  // {decrypt, AD length, message length}
  localparam logic [32:0] CASES [6] = '{
    {1'b0, 16'd16, 16'd16},
    {1'b0, 16'd5,  16'd0},
    {1'b0, 16'd0,  16'd21},
    {1'b1, 16'd20, 16'd3},
    {1'b1, 16'd33, 16'd47},
    {1'b1, 16'd0,  16'd0}
  };

  localparam logic [127:0] K1 = 128'h00112233_44556677_8899aabb_ccddeeff;
  localparam logic [127:0] K2 = 128'hf0e1d2c3_b4a59687_78695a4b_3c2d1e0f;

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int s, input int k);
    return 8'(s * 37 + k * 5 + 1);
  endfunction

  task automatic send_word(input logic [31:0] d);
    @(negedge clk);
    while (!pub_ready) @(negedge clk);
    pub_data  = d;
    pub_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    pub_valid = 1'b0;
  endtask

  task automatic send_sec(input logic [31:0] d);
    @(negedge clk);
    while (!sec_ready) @(negedge clk);
    sec_data  = d;
    sec_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    sec_valid = 1'b0;
  endtask

  task automatic send_hdr(input logic [3:0] t, input int len);
    logic [31:0] h;
    h = {t, 12'h000, 16'(len)};
    send_word(h);
    chk("R5 hdr_valid", 128'(hdr_valid), 128'd1);
    chk("R5 hdr_data", 128'(hdr_data), 128'(h));
  endtask

  task automatic check_blk(input logic [3:0] t, input int len, input int j, input bit dec);
    logic [127:0] exp, first;
    int start, n;
    start = j * 16;
    n = (len - start > 16) ? 16 : len - start;
    for (int i = 0; i < 16; i++)
      exp[127-8*i -: 8] = (i < n) ? pat(int'(t), start + i) : (i == n) ? 8'h80 : 8'h00;
    chk("R6 block presented", 128'(cb_valid), 128'd1);
    chk("R7 input stalled", 128'(pub_ready), 128'd0);
    first = cb_data;
    @(negedge clk);
    chk("R7 block held", 128'(cb_valid), 128'd1);
    chk("R7 data stable", cb_data, first);
    chk("R8 block data", cb_data, exp);
    chk("R6 byte count", 128'(cb_bytes), 128'(n));
    chk("R8 pad position", 128'(cb_padpos), (n < 16) ? (128'd1 << n) : 128'd0);
    chk("R9 last of segment", 128'(cb_last_seg), 128'(start + 16 >= len));
    chk("R9 last of input", 128'(cb_last_all), 128'((start + 16 >= len) && t == 4'h4));
    chk("R9 type", 128'(cb_type), 128'(t));
    chk("R9 ad flag", 128'(cb_is_ad), 128'(t == 4'h3));
    chk("R10 empty flag", 128'(cb_empty), 128'(len == 0));
    chk("R4 decrypt flag", 128'(cb_decrypt), 128'(dec));
    cb_take = 1'b1;
    @(negedge clk);
    cb_take = 1'b0;
    chk("R7 released", 128'(cb_valid), 128'd0);
  endtask

  task automatic send_seg(input logic [3:0] t, input int len, input bit dec);
    int nw;
    logic [31:0] w;
    send_hdr(t, len);
    if (len == 0) begin
      if (t == 4'h4) check_blk(t, 0, 0, dec);
      else chk("R10 no block for empty segment", 128'(cb_valid), 128'd0);
    end else begin
      nw = (len + 3) / 4;
      for (int k = 0; k < nw; k++) begin
        for (int b = 0; b < 4; b++)
          w[31-8*b -: 8] = (k * 4 + b < len) ? pat(int'(t), k * 4 + b) : 8'hEE;
        send_word(w);
        if (k % 4 == 3 || k == nw - 1) check_blk(t, len, k / 4, dec);
      end
    end
  endtask

  task automatic send_tag();
    logic [127:0] exp;
    logic [31:0] w;
    for (int i = 0; i < 16; i++) exp[127-8*i -: 8] = pat(5, i);
    send_hdr(4'h5, 16);
    for (int k = 0; k < 4; k++) begin
      w = exp[127-32*k -: 32];
      send_word(w);
      if (k < 3) chk("R11 tag not yet ready", 128'(xtag_ready), 128'd0);
      chk("R11 tag goes to no block", 128'(cb_valid), 128'd0);
    end
    chk("R11 tag ready", 128'(xtag_ready), 128'd1);
    chk("R11 tag value", xtag, exp);
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog act=running exp=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 pub_ready", 128'(pub_ready), 128'd1);
    chk("R1 sec_ready", 128'(sec_ready), 128'd1);
    chk("R1 cb_valid", 128'(cb_valid), 128'd0);
    chk("R1 xtag_ready", 128'(xtag_ready), 128'd0);
    chk("R1 key_fresh", 128'(key_fresh), 128'd0);

    // R3: activate before any key is staged
    send_word({4'h7, 28'h0});
    chk("R3 stall without key", 128'(pub_ready), 128'd0);
    repeat (2) @(negedge clk);
    chk("R3 still stalled", 128'(pub_ready), 128'd0);
    chk("R3 no early pulse", 128'(key_fresh), 128'd0);
    for (int i = 0; i < 4; i++) send_sec(K1[127-32*i -: 32]);
    @(negedge clk);
    chk("R3 key pulse", 128'(key_fresh), 128'd1);
    chk("R3 key value", key_out, K1);
    @(negedge clk);
    chk("R3 pulse single", 128'(key_fresh), 128'd0);
    chk("R3 pub reopened", 128'(pub_ready), 128'd1);
    chk("R3 sec reopened", 128'(sec_ready), 128'd1);

    // R2: staged key waits for activation
    for (int i = 0; i < 4; i++) send_sec(K2[127-32*i -: 32]);
    chk("R2 sec blocked", 128'(sec_ready), 128'd0);
    repeat (3) @(negedge clk);
    chk("R2 key unchanged", key_out, K1);
    chk("R2 sec still blocked", 128'(sec_ready), 128'd0);
    send_word({4'h7, 28'h0});
    @(negedge clk);
    chk("R2 staged key activated", key_out, K2);
    chk("R2 sec freed", 128'(sec_ready), 128'd1);

    for (int c = 0; c < 6; c++) begin
      logic dec;
      int adl, ml;
      dec = CASES[c][32];
      adl = int'(CASES[c][31:16]);
      ml  = int'(CASES[c][15:0]);
      send_hdr(dec ? 4'h3 : 4'h2, 0);
      chk("R11 tag cleared by instruction", 128'(xtag_ready), 128'd0);
      send_seg(4'h1, 16, dec);
      send_seg(4'h3, adl, dec);
      send_seg(4'h4, ml, dec);
      if (dec) send_tag();
      // R12 and R4: a header-shaped word here is an unknown instruction
      send_word({4'h4, 12'h000, 16'd4});
      chk("R12 read as instruction", 128'(cb_valid), 128'd0);
      chk("R4 unknown op ignored", 128'(pub_ready), 128'd1);
      send_word(32'h0000_0000);
      @(negedge clk);
      chk("R4 still no block", 128'(cb_valid), 128'd0);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule